// File: doc/BRIEF.md
# DMA Descriptor Ring Fetcher

This block walks one DMA channel through a circular list of buffer descriptors kept in memory. When the channel enable is raised, it saves the programmed first-descriptor pointer and the transfer mode. It then reads the descriptor one 32-bit word at a time over a request/grant read port. It decodes the words into buffer pointers, a length and control flags, and offers them to a downstream transfer engine with a one-cycle valid pulse.

The block then waits for the engine's done pulse and moves to the next descriptor. Descriptors are 8 bytes apart in fly-by mode, which uses two words, and 16 bytes apart in memory-to-memory mode, which uses three words. The ring closes in one of two ways. A descriptor that carries the wrap flag sends the next fetch back to the saved first address. With no wrap flag, the address rolls over at the 1024-byte ring boundary.

Top module: `dma_ring_fetch`

## Requirements
- R1: After reset and while `chanEn` is low, `memReq` and `descValid` stay low.
- R2: A rising enable from idle starts fetching at `firstPtr`. In fly-by mode (`memToMem`=0) the low 3 bits of the pointer are cleared, and in memory-to-memory mode (`memToMem`=1) the low 4 bits are cleared. The mode is sampled at that moment.
- R3: Word order is fixed. In fly-by mode, base+0 is the buffer pointer and base+4 is the control word. In memory-to-memory mode, base+0 is the source, base+4 is the destination and base+8 is the control word.
- R4: Control word decode: bit 31 is the wrap flag, bit 30 is the interrupt flag, bit 29 is the last flag, bits 28:16 are the status, bit 15 is the full flag and bits 14:0 are the length. In fly-by mode `descDst` reads 0. `descAddr` gives the descriptor base address.
- R5: `descValid` is high for exactly one cycle, in the cycle after the last word's data beat. No memory request is made until `xferDone` is seen.
- R6: After done, the next descriptor base is the current base + 8 (fly-by) or + 16 (memory-to-memory).
- R7: After a descriptor with the wrap flag set, the next base is the start address saved at enable, even if `firstPtr` has changed since then.
- R8: With no wrap flag, only the low 10 address bits advance and roll over modulo 1024. The upper bits stay fixed.
- R9: Only one read is outstanding at a time. `memAddr` stays stable while `memReq` is high and ungranted. Data is taken on `memRdValid`, in a cycle after the grant.
- R10: From the cycle after `chanEn` goes low, `memReq` and `descValid` stay low. A read that was already granted is completed and its data dropped. Re-enabling restarts at the current `firstPtr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| chanEn | input | 1 | Channel enable |
| memToMem | input | 1 | Mode: 1 = three-word memory-to-memory, 0 = two-word fly-by |
| firstPtr | input | 32 | First-descriptor address |
| xferDone | input | 1 | Transfer engine finished the presented descriptor |
| memReq | output | 1 | Word read request |
| memAddr | output | 32 | Word read address |
| memGnt | input | 1 | Read request accepted |
| memRdValid | input | 1 | Read data valid |
| memRdData | input | 32 | Read data |
| descValid | output | 1 | Decoded descriptor valid pulse |
| descAddr | output | 32 | Base address of the presented descriptor |
| descSrc | output | 32 | Buffer / source pointer |
| descDst | output | 32 | Destination pointer (0 in fly-by) |
| descLen | output | 15 | Buffer length |
| descFull | output | 1 | Bit 15 flag of the control word |
| descWrap | output | 1 | Wrap flag |
| descIntr | output | 1 | Interrupt flag |
| descLast | output | 1 | Last flag |
| descStatus | output | 13 | Status field |

## Verification
A grant takes effect at the clock edge where it is seen. Data is captured at the edge where `memRdValid` is high. `descValid` rises one cycle after the last data beat and is gone one cycle later, and the next request appears in the cycle after the edge that sampled `xferDone`. The bench drives every input and samples every output on the falling edge, so each result is read half a cycle after the edge that produced it. A scoreboard queue holds the expected descriptor sequence, and the monitor compares each `descValid` pulse against the head of that queue. Grant and data delays change from read to read, so the checks depend on the handshake and not on a fixed latency.

// File: rtl/dma_ring_pkg.sv
package dma_ring_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT, ST_HOLD} fetchState_t;

  typedef struct packed {
    logic start;     // capture pointer and mode, clear word index
    logic takeWord;  // store returned word into its field
    logic advance;   // step base to next descriptor
  } dpCtrl_t;

  localparam int WRAP_BIT = 31;
  localparam int INTR_BIT = 30;
  localparam int LAST_BIT = 29;
  localparam int STAT_HI  = 28;
  localparam int STAT_LO  = 16;
  localparam int FULL_BIT = 15;
  localparam int LEN_W    = 15;
  localparam int STAT_W   = STAT_HI - STAT_LO + 1;
endpackage

// File: rtl/dma_ring_ctrl.sv
module dma_ring_ctrl
  import dma_ring_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    chanEn,
  input  logic    xferDone,
  input  logic    memGnt,
  input  logic    memRdValid,
  input  logic    lastWord,
  output logic    memReq,
  output logic    descValid,
  output dpCtrl_t dpCtrl
);
  fetchState_t state, stateNext;
  logic validNext;

  always_comb begin
    stateNext = state;
    dpCtrl    = '0;
    validNext = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (chanEn) begin
          dpCtrl.start = 1'b1;
          stateNext    = ST_REQ;
        end
      end
      ST_REQ: begin
        if (memGnt)       stateNext = ST_WAIT;
        else if (!chanEn) stateNext = ST_IDLE;
      end
      ST_WAIT: begin
        if (memRdValid) begin
          dpCtrl.takeWord = 1'b1;
          if (!chanEn) stateNext = ST_IDLE;
          else if (lastWord) begin
            stateNext = ST_HOLD;
            validNext = 1'b1;
          end else stateNext = ST_REQ;
        end
      end
      ST_HOLD: begin
        if (!chanEn) stateNext = ST_IDLE;
        else if (xferDone) begin
          dpCtrl.advance = 1'b1;
          stateNext      = ST_REQ;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      descValid <= 1'b0;
    end else begin
      state     <= stateNext;
      descValid <= validNext;
    end
  end

  assign memReq = (state == ST_REQ);
endmodule

// File: rtl/dma_ring_dp.sv
module dma_ring_dp
  import dma_ring_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int RING_BYTES = 1024
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           dpCtrl,
  input  logic              memToMem,
  input  logic [ADDR_W-1:0] firstPtr,
  input  logic [DATA_W-1:0] memRdData,
  output logic              lastWord,
  output logic [ADDR_W-1:0] memAddr,
  output logic [ADDR_W-1:0] descAddr,
  output logic [DATA_W-1:0] descSrc,
  output logic [DATA_W-1:0] descDst,
  output logic [LEN_W-1:0]  descLen,
  output logic              descFull,
  output logic              descWrap,
  output logic              descIntr,
  output logic              descLast,
  output logic [STAT_W-1:0] descStatus
);
  localparam int RING_LSB = $clog2(RING_BYTES);
  localparam logic [RING_LSB-1:0] FLY_STEP = RING_LSB'(8);
  localparam logic [RING_LSB-1:0] M2M_STEP = RING_LSB'(16);
  localparam logic [ADDR_W-1:0]   FLY_MASK = ~ADDR_W'(7);
  localparam logic [ADDR_W-1:0]   M2M_MASK = ~ADDR_W'(15);

  logic [ADDR_W-1:0] ringStart, descBase, nextBase;
  logic              modeM2m;
  logic [1:0]        wordIdx;
  logic [RING_LSB-1:0] lowNext;

  assign lastWord = (wordIdx == (modeM2m ? 2'd2 : 2'd1));
  assign memAddr  = descBase + ADDR_W'({wordIdx, 2'b00});
  assign descAddr = descBase;
  assign lowNext  = descBase[RING_LSB-1:0] + (modeM2m ? M2M_STEP : FLY_STEP);

  generate
    if (ADDR_W > RING_LSB) begin : g_upper
      assign nextBase = descWrap ? ringStart : {descBase[ADDR_W-1:RING_LSB], lowNext};
    end else begin : g_flat
      assign nextBase = descWrap ? ringStart : ADDR_W'(lowNext);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ringStart  <= '0;
      descBase   <= '0;
      modeM2m    <= 1'b0;
      wordIdx    <= '0;
      descSrc    <= '0;
      descDst    <= '0;
      descLen    <= '0;
      descFull   <= 1'b0;
      descWrap   <= 1'b0;
      descIntr   <= 1'b0;
      descLast   <= 1'b0;
      descStatus <= '0;
    end else begin
      if (dpCtrl.start) begin
        ringStart <= firstPtr & (memToMem ? M2M_MASK : FLY_MASK);
        descBase  <= firstPtr & (memToMem ? M2M_MASK : FLY_MASK);
        modeM2m   <= memToMem;
        wordIdx   <= '0;
      end
      if (dpCtrl.takeWord) begin
        wordIdx <= lastWord ? 2'd0 : wordIdx + 2'd1;
        if (lastWord) begin
          descWrap   <= memRdData[WRAP_BIT];
          descIntr   <= memRdData[INTR_BIT];
          descLast   <= memRdData[LAST_BIT];
          descStatus <= memRdData[STAT_HI:STAT_LO];
          descFull   <= memRdData[FULL_BIT];
          descLen    <= memRdData[LEN_W-1:0];
        end else if (wordIdx == 2'd0) begin
          descSrc <= memRdData;
          if (!modeM2m) descDst <= '0;
        end else begin
          descDst <= memRdData;
        end
      end
      if (dpCtrl.advance) descBase <= nextBase;
    end
  end
endmodule

// File: rtl/dma_ring_fetch.sv
module dma_ring_fetch
  import dma_ring_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int RING_BYTES = 1024
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              chanEn,
  input  logic              memToMem,
  input  logic [ADDR_W-1:0] firstPtr,
  input  logic              xferDone,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  input  logic              memGnt,
  input  logic              memRdValid,
  input  logic [DATA_W-1:0] memRdData,
  output logic              descValid,
  output logic [ADDR_W-1:0] descAddr,
  output logic [DATA_W-1:0] descSrc,
  output logic [DATA_W-1:0] descDst,
  output logic [LEN_W-1:0]  descLen,
  output logic              descFull,
  output logic              descWrap,
  output logic              descIntr,
  output logic              descLast,
  output logic [STAT_W-1:0] descStatus
);
  dpCtrl_t dpCtrl;
  logic    lastWord;

  dma_ring_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .chanEn(chanEn), .xferDone(xferDone),
    .memGnt(memGnt), .memRdValid(memRdValid), .lastWord(lastWord),
    .memReq(memReq), .descValid(descValid), .dpCtrl(dpCtrl)
  );

  dma_ring_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RING_BYTES(RING_BYTES)) u_dp (
    .clk(clk), .rstN(rstN), .dpCtrl(dpCtrl), .memToMem(memToMem),
    .firstPtr(firstPtr), .memRdData(memRdData), .lastWord(lastWord),
    .memAddr(memAddr), .descAddr(descAddr), .descSrc(descSrc), .descDst(descDst),
    .descLen(descLen), .descFull(descFull), .descWrap(descWrap),
    .descIntr(descIntr), .descLast(descLast), .descStatus(descStatus)
  );
endmodule

// File: rtl/dma_ring_chk.sv
module dma_ring_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              chanEn,
  input logic              memReq,
  input logic              memGnt,
  input logic [ADDR_W-1:0] memAddr,
  input logic              descValid
);
  // R9
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memGnt |=> !memReq || $stable(memAddr));

  // R3
  word_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> memAddr[1:0] == 2'b00);

  // R5
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    descValid |=> !descValid);

  // R5
  no_req_on_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    descValid |-> !memReq);

  // R10
  off_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !chanEn |=> !memReq && !descValid);
endmodule

bind dma_ring_fetch dma_ring_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .chanEn(chanEn), .memReq(memReq),
  .memGnt(memGnt), .memAddr(memAddr), .descValid(descValid)
);

// File: tb/sim_dma_ring_fetch.sv
module sim_dma_ring_fetch;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN, chanEn, memToMem, xferDone, memGnt, memRdValid;
  logic [31:0] firstPtr, memRdData;
  logic        memReq, descValid, descFull, descWrap, descIntr, descLast;
  logic [31:0] memAddr, descAddr, descSrc, descDst;
  logic [14:0] descLen;
  logic [12:0] descStatus;

  dma_ring_fetch u0 (
    .clk(clk), .rstN(rstN), .chanEn(chanEn), .memToMem(memToMem), .firstPtr(firstPtr),
    .xferDone(xferDone), .memReq(memReq), .memAddr(memAddr), .memGnt(memGnt),
    .memRdValid(memRdValid), .memRdData(memRdData), .descValid(descValid),
    .descAddr(descAddr), .descSrc(descSrc), .descDst(descDst), .descLen(descLen),
    .descFull(descFull), .descWrap(descWrap), .descIntr(descIntr),
    .descLast(descLast), .descStatus(descStatus)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0;
  int bad = 0;
  logic [31:0] mem [logic [31:0]];

  typedef struct {
    logic [31:0] addr, src, dst, ctl;
    string tag;
  } expItem_t;
  expItem_t q[$];

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  function automatic logic [31:0] mkCtl(bit w, bit i, bit l, logic [12:0] st, bit f, logic [14:0] len);
    return {w, i, l, st, f, len};
  endfunction

  task automatic placeFly(input logic [31:0] a, input logic [31:0] src, input logic [31:0] ctl);
    mem[a] = src; mem[a+4] = ctl;
  endtask

  task automatic placeM2m(input logic [31:0] a, input logic [31:0] src, input logic [31:0] dst, input logic [31:0] ctl);
    mem[a] = src; mem[a+4] = dst; mem[a+8] = ctl;
  endtask

  // driver: push expected descriptor built from the layout in R3/R4
  task automatic expectDesc(input logic [31:0] a, input bit m2m, input string tag);
    expItem_t e;
    e.addr = a;
    e.src  = mem[a];
    e.dst  = m2m ? mem[a+4] : 32'h0;
    e.ctl  = m2m ? mem[a+8] : mem[a+4];
    e.tag  = tag;
    q.push_back(e);
  endtask

  task automatic checkIdle(input int n, input string tag);
    int errs = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (memReq || descValid) errs++;
    end
    check(errs == 0, tag, 32'(errs), 32'h0);
  endtask

  task automatic drainAndStop();
    int guard = 0;
    while (q.size() != 0 && guard < 5000) begin @(negedge clk); guard++; end
    repeat (4) @(negedge clk);
    chanEn = 1'b0;
  endtask

  // memory responder with varying grant and data delays (R9)
  initial begin
    int cnt = 0;
    logic [31:0] a;
    memGnt = 1'b0; memRdValid = 1'b0; memRdData = '0;
    forever begin
      @(negedge clk);
      memGnt = 1'b0; memRdValid = 1'b0;
      if (memReq) begin
        repeat (cnt % 3) @(negedge clk);
        if (memReq) begin
          a = memAddr;
          memGnt = 1'b1;
          @(negedge clk);
          memGnt = 1'b0;
          repeat ((cnt / 3) % 2) @(negedge clk);
          memRdData  = mem.exists(a) ? mem[a] : 32'hDEAD_0000;
          memRdValid = 1'b1;
          @(negedge clk);
          memRdValid = 1'b0;
        end
        cnt++;
      end
    end
  end

  // monitor: compare each valid pulse against the scoreboard head
  initial begin
    expItem_t e;
    xferDone = 1'b0;
    forever begin
      @(negedge clk);
      if (descValid) begin
        if (q.size() == 0) check(1'b0, "R5 unexpected descValid", descAddr, 32'h0);
        else begin
          e = q.pop_front();
          check(descAddr == e.addr, {e.tag, " base"}, descAddr, e.addr);
          check(descSrc == e.src && descDst == e.dst, "R3 pointers", descSrc ^ descDst, e.src ^ e.dst);
          check({descWrap, descIntr, descLast, descStatus, descFull, descLen} == e.ctl,
                "R4 control decode",
                {descWrap, descIntr, descLast, descStatus, descFull, descLen}, e.ctl);
          if (q.size() != 0) begin
            @(negedge clk);
            check(!memReq && !descValid, "R5 hold until done", {30'h0, memReq, descValid}, 32'h0);
            @(negedge clk);
            xferDone = 1'b1;
            @(negedge clk);
            xferDone = 1'b0;
          end
        end
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=running expected=finished");
    finishRun();
  end

  initial begin
    rstN = 1'b0; chanEn = 1'b0; memToMem = 1'b0; firstPtr = '0;
    // fly-by ring closed by wrap flag at 0x1010
    placeFly(32'h1000, 32'hA000_0000, mkCtl(0, 1, 0, 13'h011, 0, 15'h0040));
    placeFly(32'h1008, 32'hA000_1000, mkCtl(0, 0, 1, 13'h022, 1, 15'h7FFF));
    placeFly(32'h1010, 32'hA000_2000, mkCtl(1, 1, 1, 13'h1FFF, 0, 15'h0001));
    // memory-to-memory ring near the 1024-byte boundary, no wrap flag
    placeM2m(32'h23F0, 32'hB000_0000, 32'hC000_0000, mkCtl(0, 0, 0, 13'h005, 1, 15'h0100));
    placeM2m(32'h2000, 32'hB000_0100, 32'hC000_0100, mkCtl(0, 1, 0, 13'h006, 0, 15'h0200));
    placeM2m(32'h2010, 32'hB000_0200, 32'hC000_0200, mkCtl(0, 0, 1, 13'h007, 0, 15'h0300));
    // fly-by ring at a boundary
    placeFly(32'h33F8, 32'hD000_0000, mkCtl(0, 0, 0, 13'h0AA, 0, 15'h0010));
    placeFly(32'h3000, 32'hD000_0010, mkCtl(0, 0, 0, 13'h0BB, 1, 15'h0020));

    repeat (2) @(negedge clk);
    check(!memReq && !descValid, "R1 reset state", {30'h0, memReq, descValid}, 32'h0);
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    checkIdle(6, "R1 idle while disabled");

    // test 1: wrap flag, pointer changed after enable
    expectDesc(32'h1000, 0, "R2");
    expectDesc(32'h1008, 0, "R6");
    expectDesc(32'h1010, 0, "R6");
    expectDesc(32'h1000, 0, "R7");
    expectDesc(32'h1008, 0, "R6");
    firstPtr = 32'h1000; memToMem = 1'b0; chanEn = 1'b1;
    repeat (3) @(negedge clk);
    firstPtr = 32'h5000;
    drainAndStop();
    checkIdle(6, "R10 idle after disable");

    // test 2: memory-to-memory, unaligned pointer, boundary rollover
    expectDesc(32'h23F0, 1, "R2");
    expectDesc(32'h2000, 1, "R8");
    expectDesc(32'h2010, 1, "R6");
    firstPtr = 32'h23F7; memToMem = 1'b1; chanEn = 1'b1;
    drainAndStop();
    checkIdle(4, "R10 idle after disable");

    // test 3: fly-by rollover
    expectDesc(32'h33F8, 0, "R2");
    expectDesc(32'h3000, 0, "R8");
    firstPtr = 32'h33F8; memToMem = 1'b0; chanEn = 1'b1;
    drainAndStop();
    checkIdle(4, "R10 idle after disable");

    // test 4: disable mid-fetch, then restart at a new pointer
    firstPtr = 32'h1000; chanEn = 1'b1;
    repeat (2) @(negedge clk);
    chanEn = 1'b0;
    checkIdle(10, "R10 disable during fetch");
    check(q.size() == 0, "R10 no descriptor after abort", 32'(q.size()), 32'h0);
    expectDesc(32'h1008, 0, "R10");
    expectDesc(32'h1010, 0, "R6");
    expectDesc(32'h1008, 0, "R7");
    firstPtr = 32'h1008; chanEn = 1'b1;
    drainAndStop();
    checkIdle(4, "R10 idle after disable");
    check(q.size() == 0, "R5 all descriptors seen", 32'(q.size()), 32'h0);

    finishRun();
  end
endmodule